// File: doc/BRIEF.md
# Shift Queue with Selective Invalidation

A small in-order request queue built from a chain of shift-register slots. Slot 0 always holds the oldest entry and is shown at the dequeue port. Entries still waiting in the queue can be cancelled in place. An invalidate strobe carries a mask with one bit per slot position, and bit 0 means the head. Cancelled entries are never shown at the dequeue port. They leave the head on their own without a dequeue handshake.

A separate shift-permit input lets the surrounding logic freeze how the queue advances. While the permit is low, the head can still be taken once. The slot it leaves stays as a hole until the permit returns. This lets a consumer look at a stable window of pending requests while it decides which ones to cancel. Enqueue and dequeue use ordinary valid/ready handshakes. Both may fire in the same cycle at any depth, including depth 1.

Top module: `inval_shift_queue`

## Requirements
- R1: After reset the queue is empty: `deq_valid` is low and `enq_ready` is high.
- R2: With no invalidation and `allow_shift` high, data leaves in the order it arrived. Enqueue and dequeue may fire in the same cycle. Back-to-back dequeues have no idle cycle between them, at depth 4 and at depth 1. A head that is offered and not taken stays on `deq_data` unchanged.
- R3: When `inv_valid` is high, bit i of `inv_mask` cancels the entry i positions from the head, so bit 0 is the head. Bits that point at empty positions, or at a head that was already taken, have no effect. This includes an entry written by an enqueue in the same cycle.
- R4: If the head is cancelled in the cycle it is offered, `deq_valid` is low in that cycle and that entry is never delivered.
- R5: With `allow_shift` low, the head can be dequeued once. After that, `deq_valid` stays low, including the cycle in which `allow_shift` rises. The next entry is offered in the cycle after `allow_shift` is high.
- R6: With `allow_shift` high, a cancelled head is removed at each clock, one entry per cycle, without a handshake. If the two oldest of three entries are cancelled, the third is offered two cycles later.
- R7: If the newest entry is cancelled in the same cycle as an enqueue, the new data takes that slot. Data written that way into the head slot is offered in the next cycle. Data written that way behind a live head follows that head with no gap.
- R8: `enq_ready` is high when a slot is free, or when the head leaves this cycle with `allow_shift` high. A full depth-1 queue whose only entry is being cancelled while `allow_shift` is low keeps `enq_ready` low.
- R9: Slots emptied by cancellation are free again. A later enqueue is offered in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers `enq_data` |
| enq_ready | output | 1 | Queue accepts an entry this cycle |
| enq_data | input | WIDTH | Entry to append |
| deq_valid | output | 1 | Head entry is deliverable |
| deq_ready | input | 1 | Consumer takes the head |
| deq_data | output | WIDTH | Head entry |
| inv_valid | input | 1 | Apply `inv_mask` this cycle |
| inv_mask | input | DEPTH | Per-position cancel bits, bit 0 = head |
| allow_shift | input | 1 | Permit the slots to advance |

## Verification
The bench builds in the same cycle a handshake on a head that is also being cancelled. A design that let that head through would show a cancelled entry at the dequeue port. The bench takes a head while the shift permit is low and then raises the permit. A design that shifted early would show the second entry a cycle too soon, and one that let the hole linger would leave a gap. Cancelling the newest entry while enqueuing catches a design that appends behind the dead slot: it shows a one-cycle bubble after the head is taken, or it reports `enq_ready` high on a full depth-1 queue. The bench also drains a run of cancelled heads and then enqueues once more. This exposes slot flags that are left behind and would delay or lose the new entry.

// File: rtl/isq_pkg.sv
package isq_pkg;

    // Per-slot bookkeeping of the shift chain.
    // live  : slot takes part in the queue order (entry, cancelled entry or taken hole)
    // inv   : entry was cancelled and will never be delivered
    // taken : head entry already handed out while shifting was frozen
    typedef struct packed {
        logic live;
        logic inv;
        logic taken;
    } isq_flags_t;

    localparam isq_flags_t ISQ_FLAGS_EMPTY = '{live: 1'b0, inv: 1'b0, taken: 1'b0};
    localparam isq_flags_t ISQ_FLAGS_FRESH = '{live: 1'b1, inv: 1'b0, taken: 1'b0};

endpackage

// File: rtl/isq_head_logic.sv
module isq_head_logic
    import isq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  isq_flags_t [DEPTH-1:0] flags_q,
    input  logic                   inv_valid,
    input  logic [DEPTH-1:0]       inv_mask,
    input  logic                   deq_ready,
    input  logic                   allow_shift,
    output isq_flags_t [DEPTH-1:0] flags_m,
    output logic                   deq_valid,
    output logic                   shift
);

    logic head_kill;
    logic deq_fire;

    // A head cancelled now, or earlier, is never offered.
    assign head_kill = flags_q[0].inv | (inv_valid & inv_mask[0]);
    assign deq_valid = flags_q[0].live & ~flags_q[0].taken & ~head_kill;
    assign deq_fire  = deq_valid & deq_ready;

    // The chain advances when its head is gone for any reason and the permit is up.
    assign shift = allow_shift & flags_q[0].live
                 & (flags_q[0].taken | head_kill | deq_fire);

    for (genvar i = 0; i < DEPTH; i++) begin : g_mark
        assign flags_m[i].live = flags_q[i].live;
        assign flags_m[i].inv  = flags_q[i].inv
                               | (inv_valid & inv_mask[i] & flags_q[i].live & ~flags_q[i].taken);
        if (i == 0) begin : g_head
            assign flags_m[i].taken = flags_q[i].taken | deq_fire;
        end else begin : g_body
            assign flags_m[i].taken = flags_q[i].taken;
        end
    end

endmodule

// File: rtl/isq_tail_select.sv
module isq_tail_select #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] live_s,
    input  logic [DEPTH-1:0] inv_s,
    input  logic             enq_valid,
    output logic             enq_ready,
    output logic [DEPTH-1:0] wr_sel
);

    logic [DEPTH-1:0] at_end;
    logic [DEPTH-1:0] first_free;
    logic             reuse_tail;
    logic             enq_fire;

    // Live slots form a prefix, so the last live slot and the first free slot
    // are each found from a slot and its neighbour.
    for (genvar i = 0; i < DEPTH; i++) begin : g_edge
        if (i == DEPTH - 1) begin : g_top
            assign at_end[i] = live_s[i];
        end else begin : g_mid
            assign at_end[i] = live_s[i] & ~live_s[i+1];
        end
        if (i == 0) begin : g_bot
            assign first_free[i] = ~live_s[i];
        end else begin : g_up
            assign first_free[i] = ~live_s[i] & live_s[i-1];
        end
    end

    assign reuse_tail = |(at_end & inv_s);
    assign enq_ready  = ~live_s[DEPTH-1];
    assign enq_fire   = enq_valid & enq_ready;
    assign wr_sel     = enq_fire ? (reuse_tail ? at_end : first_free) : '0;

endmodule

// File: rtl/inval_shift_queue.sv
module inval_shift_queue
    import isq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    output logic             enq_ready,
    input  logic [WIDTH-1:0] enq_data,
    output logic             deq_valid,
    input  logic             deq_ready,
    output logic [WIDTH-1:0] deq_data,
    input  logic             inv_valid,
    input  logic [DEPTH-1:0] inv_mask,
    input  logic             allow_shift
);

    typedef struct packed {
        isq_flags_t [DEPTH-1:0]            flags;
        logic       [DEPTH-1:0][WIDTH-1:0] data;
    } isq_state_t;

    isq_state_t state_q, state_d;

    isq_flags_t [DEPTH-1:0]            flags_m;
    isq_flags_t [DEPTH-1:0]            flags_s;
    logic       [DEPTH-1:0][WIDTH-1:0] data_s;
    logic       [DEPTH-1:0]            live_s;
    logic       [DEPTH-1:0]            inv_s;
    logic       [DEPTH-1:0]            wr_sel;
    logic                              shift;

    isq_head_logic #(.DEPTH(DEPTH)) u_head (
        .flags_q    (state_q.flags),
        .inv_valid  (inv_valid),
        .inv_mask   (inv_mask),
        .deq_ready  (deq_ready),
        .allow_shift(allow_shift),
        .flags_m    (flags_m),
        .deq_valid  (deq_valid),
        .shift      (shift)
    );

    // Advance the chain by one slot when the head leaves.
    for (genvar i = 0; i < DEPTH; i++) begin : g_shift
        if (i == DEPTH - 1) begin : g_last
            assign flags_s[i] = shift ? ISQ_FLAGS_EMPTY : flags_m[i];
            assign data_s[i]  = state_q.data[i];
        end else begin : g_pass
            assign flags_s[i] = shift ? flags_m[i+1] : flags_m[i];
            assign data_s[i]  = shift ? state_q.data[i+1] : state_q.data[i];
        end
        assign live_s[i] = flags_s[i].live;
        assign inv_s[i]  = flags_s[i].inv;
    end

    isq_tail_select #(.DEPTH(DEPTH)) u_tail (
        .live_s   (live_s),
        .inv_s    (inv_s),
        .enq_valid(enq_valid),
        .enq_ready(enq_ready),
        .wr_sel   (wr_sel)
    );

    always_comb begin
        state_d.flags = flags_s;
        state_d.data  = data_s;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_sel[i]) begin
                state_d.flags[i] = ISQ_FLAGS_FRESH;
                state_d.data[i]  = enq_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign deq_data = state_q.data[0];

endmodule

// File: rtl/isq_checker.sv
module isq_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enq_ready,
    input logic             deq_valid,
    input logic             deq_ready,
    input logic [WIDTH-1:0] deq_data,
    input logic             inv_valid,
    input logic             head_mask,
    input logic             allow_shift
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!deq_valid && enq_ready));

    // A head that is offered and not taken stays put, unless it is cancelled.
    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && !deq_ready) |=> ($stable(deq_data) && (deq_valid || (inv_valid && head_mask))));

    assert_kill_hides_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && head_mask) |-> !deq_valid);

    assert_frozen_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (deq_valid && deq_ready && !allow_shift) |=> !deq_valid);

    assert_ready_on_leave_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (allow_shift && deq_valid && deq_ready) |-> enq_ready);

endmodule

bind inval_shift_queue isq_checker #(.WIDTH(WIDTH)) u_isq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enq_ready  (enq_ready),
    .deq_valid  (deq_valid),
    .deq_ready  (deq_ready),
    .deq_data   (deq_data),
    .inv_valid  (inv_valid),
    .head_mask  (inv_mask[0]),
    .allow_shift(allow_shift)
);

// File: tb/tb_inval_shift_queue.sv
`timescale 1ns/1ps
module tb_inval_shift_queue;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enq_valid = 1'b0;
    logic [7:0] enq_data = '0;
    logic       deq_ready = 1'b0;
    logic       inv_valid = 1'b0;
    logic [3:0] inv_mask = '0;
    logic       allow_shift = 1'b1;

    logic       r4_ready, r4_valid;
    logic [7:0] r4_data;
    logic       r1_ready, r1_valid;
    logic [7:0] r1_data;

    int compared = 0;
    int mismatched = 0;

    always #2.5 clk = ~clk;

    inval_shift_queue #(.DEPTH(4), .WIDTH(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(r4_ready), .enq_data(enq_data),
        .deq_valid(r4_valid), .deq_ready(deq_ready), .deq_data(r4_data),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .allow_shift(allow_shift)
    );

    inval_shift_queue #(.DEPTH(1), .WIDTH(8)) dut_d1 (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(r1_ready), .enq_data(enq_data),
        .deq_valid(r1_valid), .deq_ready(deq_ready), .deq_data(r1_data),
        .inv_valid(inv_valid), .inv_mask(inv_mask[0:0]), .allow_shift(allow_shift)
    );

    // Behavioural reference: one ordered list of pending entries per instance.
    typedef struct {
        logic [7:0] d;
        bit         inv;
        bit         taken;
    } ent_t;

    ent_t mq[2][$];
    int   mdepth[2] = '{4, 1};

    task automatic m_eval(input int k, output bit dv, output logic [7:0] dd,
                          output bit rdy, output bit sh, output bit fire);
        bit kill;
        dv = 0; dd = '0; rdy = 0; sh = 0; fire = 0;
        if (mq[k].size() > 0) begin
            kill = mq[k][0].inv || (inv_valid && inv_mask[0]);
            dv   = !mq[k][0].taken && !kill;
            dd   = mq[k][0].d;
            fire = dv && deq_ready;
            sh   = allow_shift && (mq[k][0].taken || kill || fire);
        end
        rdy = (mq[k].size() - (sh ? 1 : 0)) < mdepth[k];
    endtask

    task automatic m_update(input int k);
        bit dv, rdy, sh, fire;
        logic [7:0] dd;
        int last;
        m_eval(k, dv, dd, rdy, sh, fire);
        for (int i = 0; i < mq[k].size(); i++) begin
            if (inv_valid && inv_mask[i] && !mq[k][i].taken) mq[k][i].inv = 1;
        end
        if (fire) mq[k][0].taken = 1;
        if (sh) void'(mq[k].pop_front());
        if (enq_valid && rdy) begin
            last = mq[k].size() - 1;
            if (last >= 0 && mq[k][last].inv) begin
                mq[k][last].d   = enq_data;
                mq[k][last].inv = 0;
            end else begin
                mq[k].push_back('{d: enq_data, inv: 0, taken: 0});
            end
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_models(input string tag);
        bit dv, rdy, sh, fire;
        logic [7:0] dd;
        for (int k = 0; k < 2; k++) begin
            m_eval(k, dv, dd, rdy, sh, fire);
            chk({tag, (k == 0) ? " d4 deq_valid" : " d1 deq_valid"},
                int'(k == 0 ? r4_valid : r1_valid), int'(dv));
            chk({tag, (k == 0) ? " d4 enq_ready" : " d1 enq_ready"},
                int'(k == 0 ? r4_ready : r1_ready), int'(rdy));
            if (dv) chk({tag, (k == 0) ? " d4 deq_data" : " d1 deq_data"},
                        int'(k == 0 ? r4_data : r1_data), int'(dd));
        end
    endtask

    task automatic set_in(input bit ev, input logic [7:0] ed, input bit dr,
                          input bit al, input bit iv, input logic [3:0] im);
        enq_valid = ev; enq_data = ed; deq_ready = dr;
        allow_shift = al; inv_valid = iv; inv_mask = im;
    endtask

    task automatic look();
        #1;
    endtask

    task automatic tick(input string tag);
        #0.5;
        compare_models(tag);
        @(posedge clk);
        m_update(0);
        m_update(1);
        @(negedge clk);
    endtask

    task automatic drain();
        set_in(0, 8'h00, 1, 1, 0, 4'b0000);
        for (int n = 0; n < 6; n++) tick("R2 drain");
    endtask

    initial begin
        #1000000;
        mismatched++;
        compared++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        set_in(0, 8'h00, 0, 1, 0, 4'b0000);
        rst_n = 1'b0;
        for (int n = 0; n < 3; n++) @(negedge clk);
        look();
        chk("R1 d4 deq_valid", int'(r4_valid), 0);
        chk("R1 d4 enq_ready", int'(r4_ready), 1);
        chk("R1 d1 deq_valid", int'(r1_valid), 0);
        chk("R1 d1 enq_ready", int'(r1_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: plain FIFO order with an enqueue in the middle
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R2 fill");
        set_in(1, 8'h34, 0, 1, 0, 4'b0000); tick("R2 fill");
        set_in(1, 8'h56, 0, 1, 0, 4'b0000); tick("R2 fill");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R2 first out", int'(r4_data), 'h12); tick("R2 out");
        look(); chk("R2 second out", int'(r4_data), 'h34); tick("R2 out");
        set_in(1, 8'h78, 0, 1, 0, 4'b0000); look();
        chk("R2 ready mid", int'(r4_ready), 1); tick("R2 mid enq");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R2 third out", int'(r4_data), 'h56); tick("R2 out");
        look(); chk("R2 fourth out", int'(r4_data), 'h78); tick("R2 out");
        look(); chk("R2 empty", int'(r4_valid), 0); tick("R2 empty");

        // R2/R8: simultaneous enqueue and dequeue, both depths
        set_in(1, 8'h12, 1, 1, 0, 4'b0000); tick("R2 simul");
        set_in(1, 8'h34, 1, 1, 0, 4'b0000); look();
        chk("R2 d4 simul head", int'(r4_data), 'h12);
        chk("R2 d1 simul head", int'(r1_data), 'h12);
        chk("R8 d1 ready on leave", int'(r1_ready), 1); tick("R2 simul");
        set_in(1, 8'h56, 1, 1, 0, 4'b0000); look();
        chk("R2 d1 no bubble", int'(r1_valid), 1);
        chk("R2 d1 second", int'(r1_data), 'h34); tick("R2 simul");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R2 d1 third", int'(r1_data), 'h56); tick("R2 simul");
        look(); chk("R2 d1 empty", int'(r1_valid), 0); tick("R2 simul");

        // R5: frozen shift
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R5 fill");
        set_in(1, 8'h34, 0, 1, 0, 4'b0000); tick("R5 fill");
        set_in(0, 8'h00, 1, 0, 0, 4'b0000); look();
        chk("R5 take once", int'(r4_data), 'h12); tick("R5 take");
        look(); chk("R5 frozen", int'(r4_valid), 0); tick("R5 frozen");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R5 rise cycle", int'(r4_valid), 0); tick("R5 rise");
        look(); chk("R5 next valid", int'(r4_valid), 1);
        chk("R5 next data", int'(r4_data), 'h34); tick("R5 resume");
        drain();

        // R4: head cancelled while offered
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R4 fill");
        set_in(1, 8'h34, 0, 1, 0, 4'b0000); tick("R4 fill");
        set_in(0, 8'h00, 1, 1, 1, 4'b0001); look();
        chk("R4 hidden", int'(r4_valid), 0); tick("R4 kill");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R4 next", int'(r4_data), 'h34); tick("R4 next");
        drain();

        // R6/R9: self-draining cancelled heads, then slot reuse
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R6 fill");
        set_in(1, 8'h34, 0, 1, 0, 4'b0000); tick("R6 fill");
        set_in(1, 8'h56, 0, 1, 0, 4'b0000); tick("R6 fill");
        set_in(0, 8'h00, 0, 1, 1, 4'b0011); tick("R6 cancel two");
        set_in(0, 8'h00, 0, 1, 0, 4'b0000); look();
        chk("R6 one dropped", int'(r4_valid), 0); tick("R6 drop");
        look(); chk("R6 third valid", int'(r4_valid), 1);
        chk("R6 third data", int'(r4_data), 'h56);
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); tick("R6 take");
        look(); chk("R6 empty", int'(r4_valid), 0); tick("R6 empty");
        set_in(1, 8'h78, 0, 1, 0, 4'b0000); tick("R9 enq");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R9 reuse valid", int'(r4_valid), 1);
        chk("R9 reuse data", int'(r4_data), 'h78); tick("R9 take");
        drain();

        // R7: cancelled tail overwritten by enqueue
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R7 fill");
        set_in(1, 8'h34, 0, 1, 1, 4'b0001); tick("R7 overwrite");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R7 head valid", int'(r4_valid), 1);
        chk("R7 head data", int'(r4_data), 'h34); tick("R7 take");
        drain();
        set_in(1, 8'hAA, 0, 1, 0, 4'b0000); tick("R7 fill");
        set_in(1, 8'hBB, 0, 1, 0, 4'b0000); tick("R7 fill");
        set_in(1, 8'hCC, 0, 1, 1, 4'b0010); tick("R7 overwrite");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R7 first", int'(r4_data), 'hAA); tick("R7 take");
        look(); chk("R7 no gap", int'(r4_valid), 1);
        chk("R7 second", int'(r4_data), 'hCC); tick("R7 take");
        drain();

        // R8: full depth-1 queue, cancelled while frozen
        set_in(1, 8'h12, 0, 1, 0, 4'b0000); tick("R8 fill");
        set_in(0, 8'h00, 0, 0, 1, 4'b0001); look();
        chk("R8 d1 full frozen", int'(r1_ready), 0); tick("R8 kill");
        set_in(1, 8'h34, 0, 1, 0, 4'b0000); look();
        chk("R8 d1 ready again", int'(r1_ready), 1);
        chk("R8 d1 hidden", int'(r1_valid), 0); tick("R8 enq");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R8 d1 new head", int'(r1_data), 'h34); tick("R8 take");
        drain();

        // R3: mask bits on empty positions
        set_in(1, 8'h9A, 0, 1, 1, 4'b1111); tick("R3 enq with mask");
        set_in(0, 8'h00, 0, 1, 1, 4'b1110); look();
        chk("R3 new entry untouched", int'(r4_valid), 1);
        chk("R3 data", int'(r4_data), 'h9A); tick("R3 empty bits");
        set_in(0, 8'h00, 1, 1, 0, 4'b0000); look();
        chk("R3 still valid", int'(r4_valid), 1); tick("R3 take");
        drain();

        // Mixed stimulus compared against the reference every cycle
        for (int n = 0; n < 3000; n++) begin
            set_in(($urandom % 2) == 0, 8'($urandom), ($urandom % 4) != 0,
                   ($urandom % 5) != 0, ($urandom % 7) == 0, 4'($urandom));
            tick("R2/R3/R4/R5/R6/R7/R8 mixed");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule